// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single read and write requests from an internal port into cycles on an external bus. The same lines carry the address and then the data. Each external cycle starts with an address phase, in which the address strobe is high and the shared lines carry the target address. A data phase follows, in which the read or the write strobe is high. Two external regions are decoded from the request address: a small I/O window and a 256-Kbyte window. Each region has its own configuration inputs for data width, access length (two or three states), wait mode, one optional address wait and zero to three data waits.

A requester raises `req_valid` together with direction, size, address and write data, and holds them until `req_ack` pulses. Suppose a 16-bit request falls in a region configured for an 8-bit bus. The block then runs two back-to-back cycles, first to the even address for the upper byte and then to the odd address for the lower byte, and it acknowledges only after the second. A request outside both windows is acknowledged at once with `req_err` set, and nothing happens on the bus.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `bus_as`, `bus_rd`, `bus_wr`, `bus_ad_oe` and `req_ack` are all low.
- R2: Every external cycle begins with an address phase. In that phase `bus_as` is high, `bus_ad_oe` is high, `bus_rd` and `bus_wr` are low, and `bus_ad_o` holds the cycle address unchanged.
- R3: In a region set to two-state access (`cfg_three` bit low), the address phase lasts 1 clock and the data phase lasts 1 clock. The programmed wait fields and `bus_wait` have no effect.
- R4: In a region set to three-state access, the data phase lasts 2 + DW clocks when the wait mode is programmed-only. DW is the region's 2-bit field in `cfg_dwait` (bits [1:0] for region 0, [3:2] for region 1).
- R5: In a region set to three-state access with its `cfg_await` bit high, the address phase lasts 2 clocks instead of 1.
- R6: When a three-state region has its `cfg_pinwait` bit high, `bus_wait` is sampled at the end of the last programmed data state. Each sample that finds it high adds one data state. Without pin-wait mode, or in two-state mode, `bus_wait` is ignored.
- R7: A write drives its data on `bus_ad_o[15:0]`, with `bus_ad_oe` high, for every clock of the data phase. A read releases the bus (`bus_ad_oe` low) and captures `bus_ad_i` at the final data state.
- R8: A 16-bit request (`req_wide` high) to an 8-bit region runs two cycles. The first goes to the address with bit 0 cleared and carries bits [15:8]. The second goes to the address with bit 0 set and carries bits [7:0]. Both bytes travel on lines [7:0], and one acknowledge follows the second cycle.
- R9: A 16-bit request to a 16-bit region is a single cycle that moves all 16 bits. A byte request uses lines [7:0], and read data returns zero-extended.
- R10: A request matching neither region gets `req_ack` and `req_err` in the cycle after it is accepted, and no strobe is raised. Region 0 is the 256-byte window at base 0xFFF00 (address bits [19:8] all ones). Region 1 is the 256-Kbyte window at base 0x40000 (address bits [19:18] = 01). Region 0 wins if the two windows overlap.
- R11: `req_ack` is a single-clock pulse, raised in the clock after the last data state. At most one of `bus_as`, `bus_rd` and `bus_wr` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with acknowledge |
| req_err | output | 1 | Request hit no region, valid with acknowledge |
| cfg_wide | input | 2 | Per-region bus width, 1 = 16-bit |
| cfg_three | input | 2 | Per-region access length, 1 = three-state |
| cfg_pinwait | input | 2 | Per-region wait mode, 1 = programmed waits extended by pin |
| cfg_await | input | 2 | Per-region address wait enable |
| cfg_dwait | input | 4 | Per-region data wait count, 2 bits each |
| bus_ad_o | output | AW | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 16 | Shared lines, received value |
| bus_as | output | 1 | Address strobe, high during the address phase |
| bus_rd | output | 1 | Read strobe, high during a read data phase |
| bus_wr | output | 1 | Write strobe, high during a write data phase |
| bus_wait | input | 1 | External wait request |

## Verification
The assertions assume that the requester holds `req_valid` and its fields steady from the request until the acknowledge. They also assume that the configuration does not change while a cycle is running. The bench keeps to both rules. It drives every request on a falling edge, removes it on the falling edge where it sees the acknowledge, and changes the configuration only between accesses. `bus_wait` is driven by a bench responder that counts data states. It holds the pin high for a chosen number of extension states past the programmed ones, so each sample the design takes has a known value, even in configurations that must ignore the pin.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef struct packed {
        logic       wide;
        logic       three;
        logic       pinwait;
        logic       awt;
        logic [1:0] dwt;
    } region_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AWAIT,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Data-phase length minus one: 1 state for two-state access, 2 + waits for three-state.
    function automatic logic [2:0] data_len_m1(region_cfg_t c);
        return c.three ? (3'd1 + {1'b0, c.dwt}) : 3'd0;
    endfunction

    function automatic logic in_addr_phase(phase_e p);
        return (p == PH_ADDR) || (p == PH_AWAIT);
    endfunction

endpackage

// File: rtl/mbc_decode.sv
module mbc_decode
    import mbc_pkg::*;
#(
    parameter int AW       = 20,
    parameter int NREG     = 2,
    parameter logic [AW-1:0] R0_BASE = 20'hFFF00,
    parameter int R0_LOG2  = 8,
    parameter logic [AW-1:0] R1_BASE = 20'h40000,
    parameter int R1_LOG2  = 18
) (
    input  logic [AW-1:0]     addr,
    input  logic [NREG-1:0]   cfg_wide,
    input  logic [NREG-1:0]   cfg_three,
    input  logic [NREG-1:0]   cfg_pinwait,
    input  logic [NREG-1:0]   cfg_await,
    input  logic [2*NREG-1:0] cfg_dwait,
    output logic              hit,
    output region_cfg_t       cfg_sel
);

    logic [NREG-1:0] match;
    region_cfg_t     rcfg [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        localparam int            LOG2 = (g == 0) ? R0_LOG2 : R1_LOG2;
        localparam logic [AW-1:0] BASE = (g == 0) ? R0_BASE : R1_BASE;
        localparam logic [AW-1:0] MASK = ~((AW'(1) << LOG2) - AW'(1));

        assign match[g]         = ((addr ^ BASE) & MASK) == '0;
        assign rcfg[g].wide     = cfg_wide[g];
        assign rcfg[g].three    = cfg_three[g];
        assign rcfg[g].pinwait  = cfg_pinwait[g];
        assign rcfg[g].awt      = cfg_await[g];
        assign rcfg[g].dwt      = cfg_dwait[2*g +: 2];
    end

    // Lowest-numbered region wins on overlap.
    always_comb begin
        cfg_sel = rcfg[NREG-1];
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) cfg_sel = rcfg[i];
        end
    end

    assign hit = |match;

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_wide,
    input  logic        hit,
    input  region_cfg_t cfg_in,
    input  logic        bus_wait,
    output phase_e      phase,
    output region_cfg_t cur,
    output logic        beat,
    output logic        start,
    output logic        capture,
    output logic        err
);

    logic [2:0] cnt;
    logic       split;
    logic       pin_hold;

    assign pin_hold = cur.three && cur.pinwait && bus_wait;
    assign start    = (phase == PH_IDLE) && req_valid;
    assign capture  = (phase == PH_DATA) && (cnt == 3'd0) && !pin_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
            cnt   <= '0;
            beat  <= 1'b0;
            split <= 1'b0;
            err   <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur   <= cfg_in;
                        split <= req_wide && !cfg_in.wide;
                        beat  <= 1'b0;
                        err   <= !hit;
                        phase <= hit ? PH_ADDR : PH_DONE;
                    end
                end
                PH_ADDR: begin
                    cnt   <= data_len_m1(cur);
                    phase <= (cur.three && cur.awt) ? PH_AWAIT : PH_DATA;
                end
                PH_AWAIT: phase <= PH_DATA;
                PH_DATA: begin
                    if (cnt != 3'd0) begin
                        cnt <= cnt - 3'd1;
                    end else if (!pin_hold) begin
                        if (split && !beat) begin
                            beat  <= 1'b1;
                            phase <= PH_ADDR;
                        end else begin
                            phase <= PH_DONE;
                        end
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_two_state_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR && !cur.three) |=> (phase == PH_DATA));

    assert_two_state_data_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !cur.three) |=> (phase != PH_DATA));

    assert_addr_wait_len_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_AWAIT) |=> (phase == PH_DATA));

    assert_miss_done_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && req_valid && !hit) |=> (phase == PH_DONE && err));

    assert_second_beat_R8: assert property (@(posedge clk) disable iff (rst)
        (capture && split && !beat) |=> (phase == PH_ADDR && beat));

endmodule

// File: rtl/mbc_lane.sv
module mbc_lane #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          capture,
    input  logic          beat,
    input  logic          wide_bus,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [15:0]   bus_ad_i,
    output logic [AW-1:0] addr_out,
    output logic [15:0]   wlane,
    output logic [15:0]   rdata,
    output logic          write_q
);

    logic [AW-1:0] addr_q;
    logic [15:0]   wdata_q;
    logic          wide_q;
    logic          split;

    assign split = wide_q && !wide_bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
            write_q <= 1'b0;
            rdata   <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wide_q  <= req_wide;
            write_q <= req_write;
            rdata   <= '0;
        end else if (capture && !write_q) begin
            if (split) begin
                if (beat) rdata[7:0]  <= bus_ad_i[7:0];
                else      rdata[15:8] <= bus_ad_i[7:0];
            end else if (wide_q) begin
                rdata <= bus_ad_i;
            end else begin
                rdata <= {8'h00, bus_ad_i[7:0]};
            end
        end
    end

    always_comb begin
        if (split) begin
            addr_out = {addr_q[AW-1:1], beat};
            wlane    = {8'h00, beat ? wdata_q[7:0] : wdata_q[15:8]};
        end else begin
            addr_out = addr_q;
            wlane    = wide_q ? wdata_q : {8'h00, wdata_q[7:0]};
        end
    end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int AW       = 20,
    parameter int NREG     = 2,
    parameter logic [AW-1:0] R0_BASE = 20'hFFF00,
    parameter int R0_LOG2  = 8,
    parameter logic [AW-1:0] R1_BASE = 20'h40000,
    parameter int R1_LOG2  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ack,
    output logic [15:0]       req_rdata,
    output logic              req_err,
    input  logic [NREG-1:0]   cfg_wide,
    input  logic [NREG-1:0]   cfg_three,
    input  logic [NREG-1:0]   cfg_pinwait,
    input  logic [NREG-1:0]   cfg_await,
    input  logic [2*NREG-1:0] cfg_dwait,
    output logic [AW-1:0]     bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [15:0]       bus_ad_i,
    output logic              bus_as,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_wait
);

    localparam int PADW = AW - 16;

    region_cfg_t   cfg_sel;
    region_cfg_t   cur;
    phase_e        phase;
    logic          hit;
    logic          beat;
    logic          start;
    logic          capture;
    logic          write_q;
    logic [AW-1:0] addr_out;
    logic [15:0]   wlane;

    mbc_decode #(
        .AW(AW), .NREG(NREG),
        .R0_BASE(R0_BASE), .R0_LOG2(R0_LOG2),
        .R1_BASE(R1_BASE), .R1_LOG2(R1_LOG2)
    ) u_decode (
        .addr        (req_addr),
        .cfg_wide    (cfg_wide),
        .cfg_three   (cfg_three),
        .cfg_pinwait (cfg_pinwait),
        .cfg_await   (cfg_await),
        .cfg_dwait   (cfg_dwait),
        .hit         (hit),
        .cfg_sel     (cfg_sel)
    );

    mbc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wide  (req_wide),
        .hit       (hit),
        .cfg_in    (cfg_sel),
        .bus_wait  (bus_wait),
        .phase     (phase),
        .cur       (cur),
        .beat      (beat),
        .start     (start),
        .capture   (capture),
        .err       (req_err)
    );

    mbc_lane #(.AW(AW)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .capture   (capture),
        .beat      (beat),
        .wide_bus  (cur.wide),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_ad_i  (bus_ad_i),
        .addr_out  (addr_out),
        .wlane     (wlane),
        .rdata     (req_rdata),
        .write_q   (write_q)
    );

    assign bus_as    = in_addr_phase(phase);
    assign bus_rd    = (phase == PH_DATA) && !write_q;
    assign bus_wr    = (phase == PH_DATA) && write_q;
    assign bus_ad_oe = bus_as || bus_wr;
    assign bus_ad_o  = bus_as ? addr_out : {{PADW{1'b0}}, wlane};
    assign req_ack   = (phase == PH_DONE);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_as, bus_rd, bus_wr}));

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_ad_oe);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_as && $past(bus_as)) |-> $stable(bus_ad_o));

    assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && $past(bus_wr)) |-> $stable(bus_ad_o));

endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ack, req_err;
    logic [15:0]   req_rdata;
    logic [1:0]    cfg_wide = '0, cfg_three = '0, cfg_pinwait = '0, cfg_await = '0;
    logic [3:0]    cfg_dwait = '0;
    logic [AW-1:0] bus_ad_o;
    logic          bus_ad_oe, bus_as, bus_rd, bus_wr;
    logic [15:0]   bus_ad_i = '0;
    logic          bus_wait = 1'b0;

    int errors = 0;
    int checks = 0;

    // monitor state
    int            beat_n;
    int            as_cnt [0:2];
    int            d_cnt  [0:2];
    logic [AW-1:0] addr_seen [0:2];
    logic [15:0]   expw [0:2];
    int            dcnt;
    int            wait_target;
    logic          wbad;
    logic          prev_as;

    mux_bus_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata), .req_err(req_err),
        .cfg_wide(cfg_wide), .cfg_three(cfg_three), .cfg_pinwait(cfg_pinwait),
        .cfg_await(cfg_await), .cfg_dwait(cfg_dwait),
        .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
        .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wait(bus_wait)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int slot(input int b);
        return (b <= 0) ? 0 : ((b > 2) ? 2 : b - 1);
    endfunction

    // Bus responder and observer, active away from the rising edge.
    always @(negedge clk) begin
        if (bus_as) begin
            if (!prev_as) begin
                beat_n = beat_n + 1;
                addr_seen[slot(beat_n)] = bus_ad_o;
                dcnt = 0;
            end
            as_cnt[slot(beat_n)] = as_cnt[slot(beat_n)] + 1;
            bus_ad_i = {~bus_ad_o[7:0], bus_ad_o[7:0] ^ 8'hA5};
        end
        prev_as = bus_as;
        if (bus_rd || bus_wr) begin
            dcnt = dcnt + 1;
            d_cnt[slot(beat_n)] = d_cnt[slot(beat_n)] + 1;
            if (bus_wr && (!bus_ad_oe || bus_ad_o[15:0] != expw[slot(beat_n)])) wbad = 1'b1;
            if (bus_rd && bus_ad_oe) wbad = 1'b1;
            bus_wait = (dcnt < wait_target);
        end else begin
            bus_wait = 1'b0;
        end
    end

    function automatic logic [7:0] lo_pat(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // Issue one access; expected timing from region settings, pw = pin extension states.
    task automatic access(input logic w, input logic rw, input logic [AW-1:0] a,
                          input logic [15:0] wd, input logic miss,
                          input logic cw, input logic c3, input logic cp,
                          input logic ca, input logic [1:0] cd, input int pw);
        int prog, dexp, asexp, beats, lat, waited;
        logic split;
        logic [AW-1:0] ea0, ea1;
        logic [15:0] er;
        split = rw && !cw;
        prog  = c3 ? 2 + int'(cd) : 1;
        dexp  = prog + ((c3 && cp) ? pw : 0);
        asexp = 1 + ((c3 && ca) ? 1 : 0);
        beats = miss ? 0 : (split ? 2 : 1);
        lat   = beats * (asexp + dexp) + 1;
        ea0   = split ? {a[AW-1:1], 1'b0} : a;
        ea1   = {a[AW-1:1], 1'b1};
        expw[0] = split ? {8'h00, wd[15:8]} : (rw ? wd : {8'h00, wd[7:0]});
        expw[1] = {8'h00, wd[7:0]};
        expw[2] = 16'hxxxx;
        if (split)   er = {lo_pat(ea0), lo_pat(ea1)};
        else if (rw) er = {~a[7:0], lo_pat(a)};
        else         er = {8'h00, lo_pat(a)};
        beat_n = 0; dcnt = 0; wbad = 1'b0;
        for (int k = 0; k < 3; k++) begin as_cnt[k] = 0; d_cnt[k] = 0; end
        wait_target = prog + pw;
        req_valid = 1'b1; req_write = w; req_wide = rw; req_addr = a; req_wdata = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!req_ack && waited < 200);
        req_valid = 1'b0;
        chk(req_ack, "R11 acknowledge seen", req_ack, 1);
        chk(waited == lat, "R11 acknowledge latency", waited, lat);
        chk(req_err == miss, "R10 error flag", req_err, miss);
        chk(beat_n == beats, "R8 external cycle count", beat_n, beats);
        if (!miss) begin
            chk(as_cnt[0] == asexp, (c3 ? "R5 address phase length" : "R3 address phase length"),
                as_cnt[0], asexp);
            chk(addr_seen[0] == ea0, "R2 address of first cycle", addr_seen[0], ea0);
            chk(d_cnt[0] == dexp, (c3 ? (cp ? "R6 pin-extended data phase" : "R4 data phase length")
                                      : "R3 data phase ignores waits"), d_cnt[0], dexp);
            if (split) begin
                chk(addr_seen[1] == ea1, "R8 address of second cycle", addr_seen[1], ea1);
                chk(d_cnt[1] == dexp && as_cnt[1] == asexp, "R8 second cycle length",
                    d_cnt[1], dexp);
            end
            chk(!wbad, "R7 data lines during data phase", wbad, 0);
            if (!w) chk(req_rdata == er, (split ? "R8 merged read data" : "R9 read data lanes"),
                        req_rdata, er);
        end
        @(negedge clk);
        chk(!req_ack, "R11 acknowledge is one pulse", req_ack, 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        int n = 0;
        prev_as = 1'b0; beat_n = 0; dcnt = 0; wait_target = 0; wbad = 1'b0;
        repeat (3) @(negedge clk);
        chk(!(bus_as | bus_rd | bus_wr | bus_ad_oe | req_ack), "R1 outputs quiet in reset",
            {bus_as, bus_rd, bus_wr, bus_ad_oe, req_ack}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!(bus_as | bus_rd | bus_wr | bus_ad_oe | req_ack), "R1 outputs quiet after reset",
            {bus_as, bus_rd, bus_wr, bus_ad_oe, req_ack}, 0);

        // Sweep: region, width, length, address wait, data wait, wait mode, direction, size, pin.
        for (int r = 0; r < 2; r++)
        for (int cw = 0; cw < 2; cw++)
        for (int c3 = 0; c3 < 2; c3++)
        for (int ca = 0; ca < 2; ca++)
        for (int cd = 0; cd < 4; cd++)
        for (int cp = 0; cp < 2; cp++)
        for (int w = 0; w < 2; w++)
        for (int rw = 0; rw < 2; rw++)
        for (int pi = 0; pi < 2; pi++) begin
            cfg_wide    = r ? {cw[0], ~cw[0]} : {~cw[0], cw[0]};
            cfg_three   = r ? {c3[0], ~c3[0]} : {~c3[0], c3[0]};
            cfg_await   = r ? {ca[0], ~ca[0]} : {~ca[0], ca[0]};
            cfg_pinwait = r ? {cp[0], ~cp[0]} : {~cp[0], cp[0]};
            cfg_dwait   = r ? {cd[1:0], ~cd[1:0]} : {~cd[1:0], cd[1:0]};
            n++;
            a = r ? (20'h40000 | AW'((n * 1237) & 20'h3FFFF)) : (20'hFFF00 | AW'((n * 37) & 8'hFF));
            access(w[0], rw[0], a, 16'((n * 16'h9E37) ^ 16'h5AC3), 1'b0,
                   cw[0], c3[0], cp[0], ca[0], cd[1:0], pi * 2);
        end

        // R10: addresses outside both windows.
        cfg_three = 2'b11; cfg_await = 2'b11; cfg_dwait = 4'hF;
        access(1'b0, 1'b0, 20'h00010, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 0);
        access(1'b1, 1'b1, 20'hFFEFF, 16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 0);
        access(1'b0, 1'b1, 20'h80000, 16'h0F0F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 0);
        access(1'b1, 1'b0, 20'h3FFFF, 16'h00AA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule